// File: doc/BRIEF.md
# Playback Sample Queue for One Output Audio Slot

This block holds playback audio for a single output slot of a serial audio link controller. The host side stores 32-bit words. Each word packs two 16-bit samples. The frame side takes one sample per pop and receives it as a 20-bit slot value. The 16-bit sample sits in the upper bits of that value and the four low bits are zero.

The block tracks how many words it holds. When enough room is free for a whole refill burst, it raises a DMA request. The request stays up until the host answers with an acknowledge pulse. After that pulse, a new request can only form once the fill level has moved.

Pops on an empty queue are underruns, and writes into a full queue are overruns. Both are recorded as sticky status bits. A status read or a clear pulse resets them.

Top module: `aud_out_fifo`

## Requirements
- R1: Of each stored word, bits [15:0] are popped first and bits [31:16] second. Words leave in the order they were written.
- R2: A popped slot value carries the 16-bit sample in bits [19:4]; bits [3:0] are zero.
- R3: The depth parameter DEPTH takes 4, 8 or 16 words. Exactly DEPTH words are accepted before the queue counts as full.
- R4: status[0] (room for a burst) is 1 while the free space is at least the burst size. The burst size equals DEPTH, so at the default configuration this bit is 1 only when no word is held.
- R5: dma_req rises on the clock edge after the room condition holds while the request is armed. It then stays high until dma_ack.
- R6: dma_ack drops dma_req at the next edge and disarms it. dma_req stays low, even with room available, until the word count changes. A write and a word release in the same cycle do not count as a change.
- R7: A pop on an empty queue outputs zero, sets status[1] (underrun) and leaves the queue unchanged.
- R8: A write into a full queue is discarded and sets status[2] (overrun).
- R9: status[1] and status[2] stay set until stat_rd or flag_clr is high at a clock edge. A new event in that same cycle keeps its bit set.
- R10: A synchronous reset (rst high) empties the queue, clears both sticky bits and dma_req, and re-arms the request.
- R11: pop_sample changes only on the edge that takes a pop. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Store wr_data this cycle |
| wr_data | input | 32 | Two packed 16-bit samples |
| pop_en | input | 1 | Take one slot sample this cycle |
| pop_sample | output | 20 | Registered slot sample, left-justified |
| dma_req | output | 1 | Refill request |
| dma_ack | input | 1 | One-cycle answer that ends a request |
| stat_rd | input | 1 | Status read strobe; clears the sticky bits |
| flag_clr | input | 1 | Explicit clear of the sticky bits |
| status | output | 3 | {overrun, underrun, room for burst} |

## Verification
Each result has a fixed due time relative to its stimulus:
- pop_sample, the sticky bits and status[0] are registered, so they reflect a stimulus after the single edge that takes it.
- dma_req comes one edge later than the room condition it follows, and it falls at the edge that takes dma_ack.

The bench drives inputs and samples outputs on the falling edge. It checks each result after exactly the number of rising edges it is due. Expected slot values are computed arithmetically from the index of the word written.

// File: rtl/aof_pkg.sv
package aof_pkg;

   localparam int WORD_W   = 32;
   localparam int SAMPLE_W = 16;
   localparam int SLOT_W   = 20;
   localparam int PAD_W    = SLOT_W - SAMPLE_W;

   // status bit order matters to the decoder: thr at bit 0
   typedef struct packed {
      logic over;
      logic under;
      logic thr;
   } aof_stat_t;

   function automatic int burst_words(input int depth);
      return depth;
   endfunction

   function automatic logic [SLOT_W-1:0] justify(input logic [SAMPLE_W-1:0] s);
      return {s, {PAD_W{1'b0}}};
   endfunction

endpackage

// File: rtl/aof_store.sv
module aof_store #(
   parameter int DEPTH  = 4,
   parameter int WORD_W = 32,
   localparam int AW    = $clog2(DEPTH),
   localparam int PW    = AW + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_req,
   input  logic [WORD_W-1:0] wr_word,
   input  logic              pop_req,
   output logic              wr_ok,
   output logic              pop_ok,
   output logic              word_freed,
   output logic              half_sel,
   output logic [WORD_W-1:0] rd_word,
   output logic [PW-1:0]     level
);

   logic [PW-1:0]     wp_q, rp_q;
   logic              half_q;
   logic [WORD_W-1:0] mem_q [DEPTH];
   logic              empty, full;

   assign level      = wp_q - rp_q;
   assign empty      = (level == '0);
   assign full       = (level == PW'(DEPTH));
   assign wr_ok      = wr_req & ~full;
   assign pop_ok     = pop_req & ~empty;
   assign word_freed = pop_ok & half_q;
   assign half_sel   = half_q;
   assign rd_word    = mem_q[rp_q[AW-1:0]];

   always_ff @(posedge clk) begin
      if (rst) begin
         wp_q   <= '0;
         rp_q   <= '0;
         half_q <= 1'b0;
      end else begin
         if (wr_ok)
            wp_q <= wp_q + 1'b1;
         if (pop_ok) begin
            half_q <= ~half_q;
            if (half_q)
               rp_q <= rp_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok)
         mem_q[wp_q[AW-1:0]] <= wr_word;
   end

endmodule

// File: rtl/aof_unpack.sv
module aof_unpack
   import aof_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              pop_req,
   input  logic              pop_ok,
   input  logic              half_sel,
   input  logic [WORD_W-1:0] rd_word,
   output logic [SLOT_W-1:0] sample
);

   logic [SAMPLE_W-1:0] pick;

   always_comb begin
      if (half_sel)
         pick = rd_word[WORD_W-1:SAMPLE_W];
      else
         pick = rd_word[SAMPLE_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst)
         sample <= '0;
      else if (pop_ok)
         sample <= justify(pick);
      else if (pop_req)
         sample <= '0;
   end

endmodule

// File: rtl/aof_flags.sv
module aof_flags
   import aof_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int BURST = 4,
   localparam int PW   = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [PW-1:0] level,
   input  logic          wr_ok,
   input  logic          word_freed,
   input  logic          under_ev,
   input  logic          over_ev,
   input  logic          dma_ack,
   input  logic          stat_rd,
   input  logic          flag_clr,
   output logic          dma_req,
   output aof_stat_t     status
);

   logic thr;
   logic armed_q, req_q, under_q, over_q;
   logic lvl_moved, clr;

   generate
      if (BURST == DEPTH) begin : g_thr_empty
         assign thr = (level == '0);
      end else begin : g_thr_cmp
         logic [PW:0] free_w;
         assign free_w = (PW+1)'(DEPTH) - {1'b0, level};
         assign thr    = (free_w >= (PW+1)'(BURST));
      end
   endgenerate

   assign lvl_moved = wr_ok ^ word_freed;
   assign clr       = stat_rd | flag_clr;

   always_ff @(posedge clk) begin
      if (rst) begin
         armed_q <= 1'b1;
         req_q   <= 1'b0;
         under_q <= 1'b0;
         over_q  <= 1'b0;
      end else begin
         armed_q <= lvl_moved | (armed_q & ~dma_ack);
         req_q   <= ~dma_ack & (req_q | (armed_q & thr));
         under_q <= under_ev | (under_q & ~clr);
         over_q  <= over_ev  | (over_q  & ~clr);
      end
   end

   assign dma_req      = req_q;
   assign status.thr   = thr;
   assign status.under = under_q;
   assign status.over  = over_q;

endmodule

// File: rtl/aud_out_fifo.sv
module aud_out_fifo
   import aof_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH) + 1,
   localparam int BURST = burst_words(DEPTH)
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   input  logic        pop_en,
   output logic [19:0] pop_sample,
   output logic        dma_req,
   input  logic        dma_ack,
   input  logic        stat_rd,
   input  logic        flag_clr,
   output logic [2:0]  status
);

   generate
      if (DEPTH != 4 && DEPTH != 8 && DEPTH != 16) begin : g_bad_depth
         $error("aud_out_fifo: DEPTH must be 4, 8 or 16");
      end
      if (BURST > DEPTH) begin : g_bad_burst
         $error("aud_out_fifo: burst larger than depth");
      end
   endgenerate

   logic              wr_ok, pop_ok, word_freed, half_sel;
   logic [WORD_W-1:0] rd_word;
   logic [PW-1:0]     fill_lvl;
   aof_stat_t         stat_s;

   aof_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) store_i (
      .clk        (clk),
      .rst        (rst),
      .wr_req     (wr_en),
      .wr_word    (wr_data),
      .pop_req    (pop_en),
      .wr_ok      (wr_ok),
      .pop_ok     (pop_ok),
      .word_freed (word_freed),
      .half_sel   (half_sel),
      .rd_word    (rd_word),
      .level      (fill_lvl)
   );

   aof_unpack unpack_i (
      .clk      (clk),
      .rst      (rst),
      .pop_req  (pop_en),
      .pop_ok   (pop_ok),
      .half_sel (half_sel),
      .rd_word  (rd_word),
      .sample   (pop_sample)
   );

   aof_flags #(.DEPTH(DEPTH), .BURST(BURST)) flags_i (
      .clk        (clk),
      .rst        (rst),
      .level      (fill_lvl),
      .wr_ok      (wr_ok),
      .word_freed (word_freed),
      .under_ev   (pop_en & ~pop_ok),
      .over_ev    (wr_en & ~wr_ok),
      .dma_ack    (dma_ack),
      .stat_rd    (stat_rd),
      .flag_clr   (flag_clr),
      .dma_req    (dma_req),
      .status     (stat_s)
   );

   assign status = stat_s;

endmodule

// File: rtl/aof_chk.sv
module aof_chk #(
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH) + 1
) (
   input logic          clk,
   input logic          rst,
   input logic          wr_en,
   input logic          pop_en,
   input logic          dma_req,
   input logic          dma_ack,
   input logic          stat_rd,
   input logic          flag_clr,
   input logic [2:0]    status,
   input logic [19:0]   pop_sample,
   input logic [PW-1:0] fill_lvl
);

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      fill_lvl <= PW'(DEPTH));

   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (rst)
      dma_req && !dma_ack |=> dma_req);

   // R6
   ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
      dma_ack |=> !dma_req);

   // R7
   under_zero_chk: assert property (@(posedge clk) disable iff (rst)
      pop_en && fill_lvl == '0 |=> pop_sample == '0 && status[1] && fill_lvl == '0);

   // R8
   over_drop_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en && !pop_en && fill_lvl == PW'(DEPTH) |=> status[2] && fill_lvl == PW'(DEPTH));

   // R9
   sticky_chk: assert property (@(posedge clk) disable iff (rst)
      status[1] && !stat_rd && !flag_clr |=> status[1]);

   // R11
   hold_sample_chk: assert property (@(posedge clk) disable iff (rst)
      !pop_en |=> $stable(pop_sample));

endmodule

bind aud_out_fifo aof_chk #(.DEPTH(DEPTH)) chk_i (
   .clk        (clk),
   .rst        (rst),
   .wr_en      (wr_en),
   .pop_en     (pop_en),
   .dma_req    (dma_req),
   .dma_ack    (dma_ack),
   .stat_rd    (stat_rd),
   .flag_clr   (flag_clr),
   .status     (status),
   .pop_sample (pop_sample),
   .fill_lvl   (fill_lvl)
);

// File: tb/aud_out_fifo_tb_top.sv
`timescale 1ns/1ps
module aud_out_fifo_tb_top;

   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        pop_en = 1'b0;
   logic [19:0] pop_sample;
   logic        dma_req;
   logic        dma_ack = 1'b0;
   logic        stat_rd = 1'b0;
   logic        flag_clr = 1'b0;
   logic [2:0]  status;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   aud_out_fifo #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .pop_en(pop_en), .pop_sample(pop_sample), .dma_req(dma_req),
      .dma_ack(dma_ack), .stat_rd(stat_rd), .flag_clr(flag_clr),
      .status(status)
   );

   function automatic logic [31:0] wd(input int i);
      return {16'hA000 + 16'(i * 3), 16'h5000 + 16'(i * 7)};
   endfunction

   function automatic logic [19:0] slot_of(input int i, input int h);
      logic [31:0] w;
      w = wd(i);
      return (h == 0) ? {w[15:0], 4'h0} : {w[31:16], 4'h0};
   endfunction

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put(input logic [31:0] w);
      wr_en = 1'b1; wr_data = w;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic take();
      pop_en = 1'b1;
      tick();
      pop_en = 1'b0;
   endtask

   task automatic ack();
      dma_ack = 1'b1;
      tick();
      dma_ack = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [19:0] last;
      @(negedge clk);
      repeat (3) tick();
      // R10 reset state
      chk(status == 3'b001, "R10", 32'(status), 32'h1);
      chk(dma_req == 1'b0, "R10", 32'(dma_req), 32'h0);
      rst = 1'b0;
      tick();
      chk(dma_req == 1'b1, "R5", 32'(dma_req), 32'h1);

      for (int i = 0; i < DEPTH; i++) put(wd(i));
      chk(status == 3'b000, "R4", 32'(status), 32'h0);
      chk(dma_req == 1'b1, "R5", 32'(dma_req), 32'h1);

      put(32'hDEAD_BEEF);
      chk(status[2] == 1'b1, "R8", 32'(status), 32'h4);
      ack();
      chk(dma_req == 1'b0, "R6", 32'(dma_req), 32'h0);

      // R1 R2 R3: exactly DEPTH words come back, low half first
      for (int s = 0; s < 2 * DEPTH; s++) begin
         take();
         chk(pop_sample == slot_of(s / 2, s % 2), "R1", 32'(pop_sample),
             32'(slot_of(s / 2, s % 2)));
      end
      chk(status[0] == 1'b1, "R4", 32'(status), 32'h1);
      last = pop_sample;
      tick();
      chk(pop_sample == last, "R11", 32'(pop_sample), 32'(last));
      chk(dma_req == 1'b1, "R5", 32'(dma_req), 32'h1);

      // R7 underrun; the overrun word must not appear (R8)
      take();
      chk(pop_sample == 20'h0, "R7", 32'(pop_sample), 32'h0);
      chk(status == 3'b111, "R7", 32'(status), 32'h7);

      ack();
      for (int k = 0; k < 5; k++) begin
         tick();
         chk(dma_req == 1'b0, "R6", 32'(dma_req), 32'h0);
      end
      put(wd(100));
      chk(dma_req == 1'b0, "R6", 32'(dma_req), 32'h0);
      take();
      chk(pop_sample == slot_of(100, 0), "R2", 32'(pop_sample), 32'(slot_of(100, 0)));
      take();
      chk(pop_sample == slot_of(100, 1), "R2", 32'(pop_sample), 32'(slot_of(100, 1)));
      tick();
      chk(dma_req == 1'b1, "R6", 32'(dma_req), 32'h1);

      // R9 sticky, clear, and set-wins
      chk(status[2:1] == 2'b11, "R9", 32'(status), 32'h7);
      stat_rd = 1'b1; pop_en = 1'b1;
      tick();
      stat_rd = 1'b0; pop_en = 1'b0;
      chk(status[2:1] == 2'b01, "R9", 32'(status), 32'h3);
      flag_clr = 1'b1;
      tick();
      flag_clr = 1'b0;
      chk(status == 3'b001, "R9", 32'(status), 32'h1);

      // sweep of fill sizes with pointer wrap
      for (int r = 0; r < 24; r++) begin
         int nw;
         nw = (r % DEPTH) + 1;
         for (int i = 0; i < nw; i++) put(wd(200 + r * 8 + i));
         for (int s = 0; s < 2 * nw; s++) begin
            take();
            chk(pop_sample == slot_of(200 + r * 8 + s / 2, s % 2), "R1",
                32'(pop_sample), 32'(slot_of(200 + r * 8 + s / 2, s % 2)));
         end
         chk(status == 3'b001, "R3", 32'(status), 32'h1);
         if (dma_req) ack();
      end

      // R10 reset mid-operation
      put(wd(7)); put(wd(8)); put(wd(9)); put(wd(10)); put(wd(11));
      rst = 1'b1;
      tick();
      rst = 1'b0;
      chk(status == 3'b001, "R10", 32'(status), 32'h1);
      take();
      chk(pop_sample == 20'h0, "R10", 32'(pop_sample), 32'h0);

      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule